// File: doc/BRIEF.md
# Power-Up Strap Capture Sequencer

This block owns four dual-use pads. Each pad is a configuration strap while the supply comes up and a clock output once the chip is running. After reset every pad driver stays off so the board straps can be read. A settling counter runs first. The strap levels, resolved through a model of the internal pull-ups, pass through a synchroniser. They must then match on several consecutive cycles before they are captured into internal registers. Only after the capture are the pad drivers switched on, so the pads carry their clock sources.

Two of the pads carry the reference clock and hold the host current multiple selection. The other two carry the 48 MHz clock and hold the frequency selection. The captured values stay frozen until the next reset, even though the pads toggle as clocks. The block also decodes the two multiple-select bits into the multiplier of the host output current, between 4 and 7. If the straps never settle, a qualification limit forces a capture, so the outputs come up within a bounded time.

Top module: `strap_capture_seq`

## Requirements
- R1: While reset is active, `pad_oe_o` is 0000, `capture_done_o` is 0, `pad_out_o` is 0000, all four captured strap outputs are 1, and `drv_mult_o` is 7.
- R2: Strap bit order is [0] multiple-select low, [1] multiple-select high, [2] frequency select A, [3] frequency select B. A pad whose `strap_drv_i` bit is 0 reads as 1. A pad whose `strap_drv_i` bit is 1 reads as its `strap_val_i` bit. The captured outputs hold these resolved levels.
- R3: Nothing is captured during the first SETTLE_CYCLES clock edges after reset. With steady straps, `capture_done_o` rises after edge SETTLE_CYCLES+RUN_LEN and is still 0 after edge SETTLE_CYCLES+RUN_LEN-1.
- R4: Capture needs RUN_LEN consecutive cycles in which the synchronised strap vector is unchanged. A strap change made just after edge SETTLE_CYCLES reaches the comparison two edges later and restarts the run, so the capture moves to edge SETTLE_CYCLES+RUN_LEN+3 and takes the new level.
- R5: If no qualifying run completes, the straps are captured anyway after edge SETTLE_CYCLES+QUAL_LIMIT.
- R6: `capture_done_o` and all four `pad_oe_o` bits rise on the same edge and stay high until reset. `pad_out_o` is 0000 while disabled. Once enabled, bits [1:0] follow `ref_clk_i` and bits [3:2] follow `f48_clk_i`.
- R7: After capture, any change on `strap_drv_i` or `strap_val_i` leaves the captured outputs and `drv_mult_o` unchanged.
- R8: `drv_mult_o` decodes (low, high) multiple-select bits as (0,0)=5, (0,1)=6, (1,0)=4 and (1,1)=7.
- R9: Capture happens exactly once per reset. A new reset repeats the whole sequence and captures the current strap levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_drv_i | input | 4 | Per pad: 1 when the board actively drives the strap level |
| strap_val_i | input | 4 | Per pad: level driven by the board, used only where driven |
| ref_clk_i | input | 1 | Reference clock source for pads [1:0] |
| f48_clk_i | input | 1 | 48 MHz clock source for pads [3:2] |
| pad_oe_o | output | 4 | Pad output driver enables |
| pad_out_o | output | 4 | Pad output data |
| capture_done_o | output | 1 | Straps captured and drivers enabled |
| cfg_mult0_o | output | 1 | Captured multiple-select low bit |
| cfg_mult1_o | output | 1 | Captured multiple-select high bit |
| cfg_fsel_a_o | output | 1 | Captured frequency select A |
| cfg_fsel_b_o | output | 1 | Captured frequency select B |
| drv_mult_o | output | 3 | Host output current multiple (4 to 7) |

## Verification
On every cycle the assertions check these invariants:
- The drivers stay off until the capture is done, and then all of them come on at once.
- The done flag never falls before reset.
- Exactly one capture pulse happens, and only after the settle interval.
- The captured values stay frozen afterwards, and the multiplier stays in range.

The exact edge on which the capture lands can only be shown by the bench scenarios. This covers the steady, restarted and timed-out qualifications, together with the pull-up resolution of undriven pads and the decoded multiplier values.

// File: rtl/strap_seq_pkg.sv
package strap_seq_pkg;

  localparam int unsigned STRAP_W = 4;
  localparam int unsigned IDX_M0  = 0;
  localparam int unsigned IDX_M1  = 1;
  localparam int unsigned IDX_FA  = 2;
  localparam int unsigned IDX_FB  = 3;

  typedef enum logic [1:0] {
    PH_SETTLE = 2'd0,
    PH_QUAL   = 2'd1,
    PH_RUN    = 2'd2
  } phase_e;

  // Host current multiple from the two captured select bits.
  function automatic logic [2:0] host_mult(input logic m0, input logic m1);
    logic [2:0] r;
    case ({m0, m1})
      2'b00:   r = 3'd5;
      2'b01:   r = 3'd6;
      2'b10:   r = 3'd4;
      default: r = 3'd7;
    endcase
    return r;
  endfunction

  // Pull-up resolution: an undriven pad reads high.
  function automatic logic pad_level(input logic drv, input logic val);
    return drv ? val : 1'b1;
  endfunction

endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] drv_i,
  input  logic [W-1:0] val_i,
  output logic [W-1:0] sync_o
);
  import strap_seq_pkg::*;

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    logic              lvl;

    assign lvl = pad_level(drv_i[b], val_i[b]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;
      else if (STAGES == 1) chain_q <= lvl;
      else chain_q <= {chain_q[STAGES-2:0], lvl};
    end

    assign sync_o[b] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/strap_qualifier.sv
module strap_qualifier #(
  parameter int unsigned W       = 4,
  parameter int unsigned RUN_LEN = 4,
  parameter int unsigned LIMIT   = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         arm_i,
  input  logic [W-1:0] sample_i,
  output logic         accept_o,
  output logic         timeout_o
);
  localparam int unsigned RUN_W = $clog2(RUN_LEN + 1);
  localparam int unsigned LIM_W = $clog2(LIMIT + 1);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(RUN_LEN - 1);
  localparam logic [LIM_W-1:0] LIM_LAST = LIM_W'(LIMIT - 1);

  logic [W-1:0]     prev_q;
  logic [RUN_W-1:0] run_q;
  logic [LIM_W-1:0] wait_q;
  logic             same;

  assign same      = (sample_i == prev_q);
  assign accept_o  = arm_i && same && (run_q == RUN_LAST);
  assign timeout_o = arm_i && (wait_q == LIM_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '1;
      run_q  <= '0;
      wait_q <= '0;
    end else begin
      prev_q <= sample_i;
      if (!arm_i) begin
        run_q  <= '0;
        wait_q <= '0;
      end else begin
        if (!same) run_q <= '0;
        else if (run_q != RUN_LAST) run_q <= run_q + 1'b1;
        if (wait_q != LIM_LAST) wait_q <= wait_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/strap_seq_ctrl.sv
module strap_seq_ctrl #(
  parameter int unsigned SETTLE_CYCLES = 150000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  accept_i,
  input  logic                  timeout_i,
  output strap_seq_pkg::phase_e phase_o,
  output logic                  settle_done_o,
  output logic                  latch_en_o
);
  import strap_seq_pkg::*;

  localparam int unsigned CNT_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYCLES - 1);

  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q;

  assign settle_done_o = (phase_q == PH_SETTLE) && (cnt_q == CNT_LAST);
  assign latch_en_o    = (phase_q == PH_QUAL) && (accept_i || timeout_i);
  assign phase_o       = phase_q;

  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      PH_SETTLE: if (settle_done_o) phase_d = PH_QUAL;
      PH_QUAL:   if (latch_en_o)    phase_d = PH_RUN;
      default:   phase_d = PH_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_SETTLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      if (phase_q == PH_SETTLE && !settle_done_o) cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/strap_capture_seq.sv
module strap_capture_seq #(
  parameter int unsigned SETTLE_CYCLES = 150000,
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned RUN_LEN       = 4,
  parameter int unsigned QUAL_LIMIT    = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] strap_drv_i,
  input  logic [3:0] strap_val_i,
  input  logic       ref_clk_i,
  input  logic       f48_clk_i,
  output logic [3:0] pad_oe_o,
  output logic [3:0] pad_out_o,
  output logic       capture_done_o,
  output logic       cfg_mult0_o,
  output logic       cfg_mult1_o,
  output logic       cfg_fsel_a_o,
  output logic       cfg_fsel_b_o,
  output logic [2:0] drv_mult_o
);
  import strap_seq_pkg::*;

  localparam int unsigned W = STRAP_W;

  logic [W-1:0] sync_w;
  logic [W-1:0] lat_q;
  logic [W-1:0] src_w;
  logic         accept_w;
  logic         timeout_w;
  logic         settle_done_w;
  logic         latch_en_w;
  phase_e       phase_w;

  strap_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .drv_i  (strap_drv_i),
    .val_i  (strap_val_i),
    .sync_o (sync_w)
  );

  strap_qualifier #(.W(W), .RUN_LEN(RUN_LEN), .LIMIT(QUAL_LIMIT)) u_qual (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm_i     (phase_w == PH_QUAL),
    .sample_i  (sync_w),
    .accept_o  (accept_w),
    .timeout_o (timeout_w)
  );

  strap_seq_ctrl #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .accept_i      (accept_w),
    .timeout_i     (timeout_w),
    .phase_o       (phase_w),
    .settle_done_o (settle_done_w),
    .latch_en_o    (latch_en_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_q <= '1;
    else if (latch_en_w) lat_q <= sync_w;
  end

  assign capture_done_o = (phase_w == PH_RUN);
  assign src_w = {f48_clk_i, f48_clk_i, ref_clk_i, ref_clk_i};

  for (genvar p = 0; p < W; p++) begin : g_pad
    assign pad_oe_o[p]  = capture_done_o;
    assign pad_out_o[p] = capture_done_o & src_w[p];
  end

  assign cfg_mult0_o  = lat_q[IDX_M0];
  assign cfg_mult1_o  = lat_q[IDX_M1];
  assign cfg_fsel_a_o = lat_q[IDX_FA];
  assign cfg_fsel_b_o = lat_q[IDX_FB];
  assign drv_mult_o   = host_mult(lat_q[IDX_M0], lat_q[IDX_M1]);

endmodule

// File: rtl/strap_capture_seq_chk.sv
module strap_capture_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       done,
  input logic [3:0] oe,
  input logic [3:0] lat,
  input logic [2:0] mult,
  input logic       latch_en,
  input logic       settle_done
);
  logic seen_settle_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_settle_q <= 1'b0;
    else if (settle_done) seen_settle_q <= 1'b1;
  end

  AST_NO_OE_BEFORE_DONE: assert property (@(posedge clk) disable iff (!rst_n) !done |-> oe == 4'b0000); // R6
  AST_OE_ALL_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n) $rose(done) |-> oe == 4'b1111); // R6
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n) $past(done) |-> done); // R6
  AST_LATCH_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) done && $past(done) |-> $stable(lat) && $stable(mult)); // R7
  AST_SINGLE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n) latch_en |=> !latch_en && done); // R9
  AST_SETTLE_FIRST: assert property (@(posedge clk) disable iff (!rst_n) latch_en |-> seen_settle_q); // R3
  AST_MULT_RANGE: assert property (@(posedge clk) disable iff (!rst_n) done |-> mult >= 3'd4); // R8

endmodule

bind strap_capture_seq strap_capture_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .done        (capture_done_o),
  .oe          (pad_oe_o),
  .lat         ({cfg_fsel_b_o, cfg_fsel_a_o, cfg_mult1_o, cfg_mult0_o}),
  .mult        (drv_mult_o),
  .latch_en    (latch_en_w),
  .settle_done (settle_done_w)
);

// File: tb/test_strap_capture_seq.sv
module test_strap_capture_seq;
  localparam int SETTLE = 40;
  localparam int RUN    = 4;
  localparam int LIMIT  = 20;

  typedef struct packed {
    logic [3:0] drv;
    logic [3:0] val;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{4'b0000, 4'b0000},
    '{4'b1111, 4'b0000},
    '{4'b1111, 4'b0010},
    '{4'b1111, 4'b0001},
    '{4'b0011, 4'b0100},
    '{4'b1100, 4'b0100},
    '{4'b1010, 4'b1000}
  };

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n;
  logic [3:0] drv, val;
  logic       ref_clk, f48_clk;
  logic [3:0] oe, pout;
  logic       done, m0, m1, fa, fb;
  logic [2:0] mult;

  strap_capture_seq #(.SETTLE_CYCLES(SETTLE), .SYNC_STAGES(2), .RUN_LEN(RUN), .QUAL_LIMIT(LIMIT))
  i_strap_capture_seq (
    .clk(clk), .rst_n(rst_n), .strap_drv_i(drv), .strap_val_i(val),
    .ref_clk_i(ref_clk), .f48_clk_i(f48_clk), .pad_oe_o(oe), .pad_out_o(pout),
    .capture_done_o(done), .cfg_mult0_o(m0), .cfg_mult1_o(m1),
    .cfg_fsel_a_o(fa), .cfg_fsel_b_o(fb), .drv_mult_o(mult)
  );

  int edges;
  always @(posedge clk) if (!rst_n) edges <= 0; else edges <= edges + 1;

  int checks = 0;
  int errors = 0;

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] resolve(input logic [3:0] d, input logic [3:0] v);
    return (d & v) | ~d;
  endfunction

  function automatic logic [31:0] mult_of(input logic a0, input logic a1);
    int r;
    r = 5 + int'(a1) - int'(a0) + 2 * int'(a0) * int'(a1);
    return 32'(r);
  endfunction

  function automatic logic [3:0] lat_vec();
    return {fb, fa, m1, m0};
  endfunction

  task automatic to_edge(input int n);
    while (edges < n) @(negedge clk);
  endtask

  task automatic do_reset(input logic [3:0] d, input logic [3:0] v);
    rst_n = 1'b0;
    drv = d;
    val = v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "oe in reset", 32'(oe), 32'h0);
    check("R1", "done in reset", 32'(done), 32'h0);
    check("R1", "pads in reset", 32'(pout), 32'h0);
    check("R1", "straps in reset", 32'(lat_vec()), 32'hF);
    check("R1", "mult in reset", 32'(mult), 32'd7);
    rst_n = 1'b1;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0] exp;
    logic [3:0] held;
    ref_clk = 1'b1;
    f48_clk = 1'b0;
    rst_n = 1'b0;
    drv = '0;
    val = '0;

    // Table walk: steady straps, exact capture edge, resolution, decode, hold
    for (int i = 0; i < 7; i++) begin
      do_reset(VECS[i].drv, VECS[i].val);
      exp = resolve(VECS[i].drv, VECS[i].val);
      to_edge(SETTLE + RUN - 1);
      check("R3", "done before capture edge", 32'(done), 32'h0);
      check("R6", "oe before capture", 32'(oe), 32'h0);
      check("R6", "pads before capture", 32'(pout), 32'h0);
      to_edge(SETTLE + RUN);
      check("R3", "done at capture edge", 32'(done), 32'h1);
      check("R6", "oe with done", 32'(oe), 32'hF);
      check("R6", "pads follow sources", 32'(pout), 32'({f48_clk, f48_clk, ref_clk, ref_clk}));
      check("R2", "captured straps", 32'(lat_vec()), 32'(exp));
      check("R9", "recapture after reset", 32'(lat_vec()), 32'(exp));
      check("R8", "decoded multiple", 32'(mult), mult_of(exp[0], exp[1]));
      held = lat_vec();
      drv = ~drv;
      val = ~val;
      ref_clk = ~ref_clk;
      f48_clk = ~f48_clk;
      repeat (8) @(negedge clk);
      check("R7", "straps frozen", 32'(lat_vec()), 32'(held));
      check("R7", "mult frozen", 32'(mult), mult_of(held[0], held[1]));
      check("R6", "done held", 32'(done), 32'h1);
      check("R6", "pads follow new sources", 32'(pout), 32'({f48_clk, f48_clk, ref_clk, ref_clk}));
    end

    // Strap change right after the settle interval restarts qualification
    do_reset(4'b1111, 4'b0000);
    to_edge(SETTLE);
    val[2] = 1'b1;
    to_edge(SETTLE + RUN);
    check("R4", "no capture at nominal edge", 32'(done), 32'h0);
    to_edge(SETTLE + RUN + 2);
    check("R4", "still qualifying", 32'(done), 32'h0);
    to_edge(SETTLE + RUN + 3);
    check("R4", "capture after restart", 32'(done), 32'h1);
    check("R4", "new level captured", 32'(lat_vec()), 32'h4);

    // Continuously toggling strap forces a capture at the limit
    do_reset(4'b1111, 4'b0010);
    while (edges < SETTLE + LIMIT - 1) begin
      @(negedge clk);
      val[3] = ~val[3];
    end
    check("R5", "no capture before limit", 32'(done), 32'h0);
    @(negedge clk);
    check("R5", "capture at limit", 32'(done), 32'h1);
    check("R5", "steady bits captured", 32'(lat_vec() & 4'h7), 32'h2);
    check("R8", "mult after forced capture", 32'(mult), 32'd6);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule